// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs single accesses on an external asynchronous-style memory bus that is split into five chip-select spaces. A requester presents an address, a direction, a space number, write data and byte-lane enables. When the sequencer is idle it takes the request and drives the bus through a setup cycle, one or more wait cycles, optional extra hold cycles and a closing cycle. It then raises a one-clock completion pulse, with captured read data for reads.

The external memory can stretch an access by holding the active-low WAIT input low. Once WAIT is seen high, the strobes are released after a delay that depends on the space. Spaces 0 to 3 always release after one clock. Space 4 releases after 1, 2 or 4 clocks, chosen by a 2-bit configuration field. A DMA acknowledge output can be asserted with the access strobes, and its polarity is configurable.

Top module: `xbus_wait_seq`

## Requirements
- R1: While reset is held and right after it is released, every chip-select, the read strobe, the write strobes and the bus-start output are high, data output-enable, done and the DMA acknowledge are low, and req_ready is high.
- R2: A request is taken only when req_ready is high, and req_ready is high only while no access is in progress. A request held or altered during an access does not change the bus address or space of that access and does not start a second access.
- R3: An access begins with exactly one cycle in which bus_start_n is low. In every cycle of the access exactly the chip-select whose index equals the requested space is low, and all chip-selects are high between accesses.
- R4: For spaces 0 to 3, an access in which WAIT is low on k consecutive wait-cycle edges keeps the chip-select low for exactly 3 + k clocks. The strobes go high one clock after WAIT is first sampled high.
- R5: For space 4 the release delay N is set by the hold field: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 4. The chip-select stays low for exactly 2 + (k + 1) + (N − 1) clocks.
- R6: At least one wait cycle is always inserted, so even with WAIT constantly high an access lasts at least 3 clocks. Each edge that samples WAIT low adds one clock.
- R7: During a read, bus_rd_n is low and all write strobes are high for every cycle of the access, and the output-enable stays low. The value on bus_data_in in the last access cycle appears on rdata together with done.
- R8: During a write, bus_we_n equals the inverted byte-lane enables and bus_rd_n is high for every access cycle. The output-enable is high from the first through the last access cycle, and bus_data_out carries the write data. bus_addr holds the requested address throughout every access.
- R9: With cfg_dack_low = 0 the DMA acknowledge is high during the access cycles of a request flagged req_dma, and low otherwise. With cfg_dack_low = 1 the levels are inverted. Requests not flagged DMA leave it at its inactive level.
- R10: The hold field and the acknowledge polarity are sampled when a request is taken. Changing them during an access affects neither that access's length nor its acknowledge levels.
- R11: done is high for exactly one clock, in the first cycle after the chip-select returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | High while idle; a request is taken on an edge where both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 3 | Chip-select space, 0 to 4 |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables for the write strobes |
| req_dma | input | 1 | Assert the DMA acknowledge for this access |
| cfg_tail_sel | input | 2 | Space 4 release delay select |
| cfg_dack_low | input | 1 | 1 = DMA acknowledge active low |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with done after a read |
| bus_addr | output | 24 | Bus address |
| bus_cs_n | output | 5 | Chip-selects, active low, one per space |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 2 | Write strobes per byte lane, active low |
| bus_start_n | output | 1 | Bus-start pulse, active low |
| bus_dack | output | 1 | DMA acknowledge |
| bus_wait_n | input | 1 | External wait, active low, synchronous to clk |
| bus_data_out | output | 16 | Write data toward the bus |
| bus_data_oe | output | 1 | Data output-enable |
| bus_data_in | input | 16 | Read data from the bus |

## Verification
The checker assumes that req_space never exceeds 4 when a request is taken, and that bus_wait_n is already synchronous to clk. The bench keeps to both: it draws the space from the five legal values, including the altered space of a held request, and changes WAIT only on falling edges. Given those inputs, the checker expects one-hot-or-idle chip-selects, mutually exclusive read and write strobes, a stable address within an access and a single-clock done pulse.

// File: rtl/xbw_pkg.sv
`timescale 1ns/1ps
package xbw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_TW   = 3'd2,
        PH_TWX  = 3'd3,
        PH_T2   = 3'd4
    } phase_e;

    // Release-delay select codes for the long-hold space
    localparam logic [1:0] TAIL_1 = 2'b00;
    localparam logic [1:0] TAIL_2 = 2'b01;
    localparam logic [1:0] TAIL_4 = 2'b10;

endpackage

// File: rtl/xbw_tail_calc.sv
`timescale 1ns/1ps
// Number of extra post-wait cycles (release delay minus one) for a space.
module xbw_tail_calc #(
    parameter int SPACE_W    = 3,
    parameter int LONG_SPACE = 4,
    parameter int CNT_W      = 2
) (
    input  logic [SPACE_W-1:0] space,
    input  logic [1:0]         sel,
    output logic [CNT_W-1:0]   extra
);
    import xbw_pkg::*;

    always_comb begin
        extra = '0;
        if (space == SPACE_W'(LONG_SPACE)) begin
            unique case (sel)
                TAIL_1:  extra = CNT_W'(0);
                TAIL_2:  extra = CNT_W'(1);
                TAIL_4:  extra = CNT_W'(3);
                default: extra = CNT_W'(3);
            endcase
        end
    end
endmodule

// File: rtl/xbw_cs_decode.sv
`timescale 1ns/1ps
// Active-low chip-select per space.
module xbw_cs_decode #(
    parameter int NUM_SPACES = 5,
    parameter int SPACE_W    = 3
) (
    input  logic                  active,
    input  logic [SPACE_W-1:0]    space,
    output logic [NUM_SPACES-1:0] cs_n
);
    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_cs
        assign cs_n[g] = !(active && (space == SPACE_W'(g)));
    end
endmodule

// File: rtl/xbw_strobe_gen.sv
`timescale 1ns/1ps
// Derives bus strobes from the registered access phase.
module xbw_strobe_gen #(
    parameter int LANES = 2
) (
    input  xbw_pkg::phase_e   phase,
    input  logic              write,
    input  logic              dma,
    input  logic              dack_low,
    input  logic [LANES-1:0]  be,
    output logic              active,
    output logic              start_n,
    output logic              rd_n,
    output logic [LANES-1:0]  we_n,
    output logic              oe,
    output logic              dack
);
    import xbw_pkg::*;

    assign active  = (phase != PH_IDLE);
    assign start_n = (phase != PH_T1);
    assign rd_n    = !(active && !write);
    assign we_n    = (active && write) ? ~be : '1;
    assign oe      = active && write;
    assign dack    = (active && dma) ^ dack_low;
endmodule

// File: rtl/xbus_wait_seq.sv
`timescale 1ns/1ps
module xbus_wait_seq #(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter int LANES      = 2,
    parameter int NUM_SPACES = 5,
    parameter int LONG_SPACE = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [$clog2(NUM_SPACES)-1:0] req_space,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic [LANES-1:0]              req_be,
    input  logic                          req_dma,
    input  logic [1:0]                    cfg_tail_sel,
    input  logic                          cfg_dack_low,
    output logic                          done,
    output logic [DATA_W-1:0]             rdata,
    output logic [ADDR_W-1:0]             bus_addr,
    output logic [NUM_SPACES-1:0]         bus_cs_n,
    output logic                          bus_rd_n,
    output logic [LANES-1:0]              bus_we_n,
    output logic                          bus_start_n,
    output logic                          bus_dack,
    input  logic                          bus_wait_n,
    output logic [DATA_W-1:0]             bus_data_out,
    output logic                          bus_data_oe,
    input  logic [DATA_W-1:0]             bus_data_in
);
    import xbw_pkg::*;

    localparam int SPACE_W = $clog2(NUM_SPACES);
    localparam int CNT_W   = 2;

    typedef struct packed {
        phase_e              phase;
        logic [SPACE_W-1:0]  space;
        logic                write;
        logic                dma;
        logic                dack_low;
        logic [LANES-1:0]    be;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                done;
    } seq_t;

    seq_t             s_q, s_d;
    logic [CNT_W-1:0] tail_extra;
    logic             active;

    xbw_tail_calc #(
        .SPACE_W    (SPACE_W),
        .LONG_SPACE (LONG_SPACE),
        .CNT_W      (CNT_W)
    ) u_tail (
        .space (req_space),
        .sel   (cfg_tail_sel),
        .extra (tail_extra)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase    = PH_T1;
                    s_d.space    = req_space;
                    s_d.write    = req_write;
                    s_d.dma      = req_dma;
                    s_d.dack_low = cfg_dack_low;
                    s_d.be       = req_be;
                    s_d.cnt      = tail_extra;
                    s_d.addr     = req_addr;
                    s_d.wdata    = req_wdata;
                end
            end
            PH_T1: s_d.phase = PH_TW;
            PH_TW: begin
                if (bus_wait_n) begin
                    s_d.phase = (s_q.cnt == '0) ? PH_T2 : PH_TWX;
                end
            end
            PH_TWX: begin
                if (s_q.cnt <= CNT_W'(1)) begin
                    s_d.phase = PH_T2;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_T2: begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
                if (!s_q.write) begin
                    s_d.rdata = bus_data_in;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    xbw_strobe_gen #(
        .LANES (LANES)
    ) u_strobe (
        .phase    (s_q.phase),
        .write    (s_q.write),
        .dma      (s_q.dma),
        .dack_low (s_q.dack_low),
        .be       (s_q.be),
        .active   (active),
        .start_n  (bus_start_n),
        .rd_n     (bus_rd_n),
        .we_n     (bus_we_n),
        .oe       (bus_data_oe),
        .dack     (bus_dack)
    );

    xbw_cs_decode #(
        .NUM_SPACES (NUM_SPACES),
        .SPACE_W    (SPACE_W)
    ) u_cs (
        .active (active),
        .space  (s_q.space),
        .cs_n   (bus_cs_n)
    );

    assign req_ready    = (s_q.phase == PH_IDLE);
    assign done         = s_q.done;
    assign rdata        = s_q.rdata;
    assign bus_addr     = s_q.addr;
    assign bus_data_out = s_q.wdata;

endmodule

// File: rtl/xbw_checker.sv
`timescale 1ns/1ps
module xbw_checker #(
    parameter int ADDR_W     = 24,
    parameter int LANES      = 2,
    parameter int NUM_SPACES = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic [$clog2(NUM_SPACES)-1:0] req_space,
    input logic                          done,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [NUM_SPACES-1:0]         bus_cs_n,
    input logic                          bus_rd_n,
    input logic [LANES-1:0]              bus_we_n,
    input logic                          bus_start_n,
    input logic                          bus_data_oe
);
    localparam int SPACE_W = $clog2(NUM_SPACES);

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (&bus_cs_n && bus_rd_n && &bus_we_n && bus_start_n && !done && req_ready));

    a_r2_space_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (req_space < SPACE_W'(NUM_SPACES)));

    a_r2_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> &bus_cs_n);

    a_r3_cs_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bus_cs_n) <= 1);

    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_start_n |=> bus_start_n);

    a_r3_start_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_start_n |-> ($countones(~bus_cs_n) == 1));

    a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (&bus_we_n && !bus_data_oe));

    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&bus_cs_n) && bus_start_n) |-> $stable(bus_addr));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&bus_cs_n && !(&$past(bus_cs_n))));
endmodule

bind xbus_wait_seq xbw_checker #(
    .ADDR_W     (ADDR_W),
    .LANES      (LANES),
    .NUM_SPACES (NUM_SPACES)
) u_xbw_checker (.*);

// File: tb/xbus_wait_seq_bench.sv
`timescale 1ns/1ps
module xbus_wait_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [2:0]  req_space = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_dma = 1'b0;
    logic [1:0]  cfg_tail_sel = '0;
    logic        cfg_dack_low = 1'b0;
    logic        done;
    logic [15:0] rdata;
    logic [23:0] bus_addr;
    logic [4:0]  bus_cs_n;
    logic        bus_rd_n;
    logic [1:0]  bus_we_n;
    logic        bus_start_n;
    logic        bus_dack;
    logic        bus_wait_n = 1'b1;
    logic [15:0] bus_data_out;
    logic        bus_data_oe;
    logic [15:0] bus_data_in = '0;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    xbus_wait_seq u_xbus_wait_seq (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic logic [15:0] pat(input int n, input int idx);
        return 16'(16'h3C00 + n * 16'h0111 + idx * 16'h0007);
    endfunction

    task automatic check_idle_outputs(input string req);
        chk(bus_cs_n == 5'h1F, req, "cs_n idle", bus_cs_n, 5'h1F);
        chk(bus_rd_n && bus_we_n == 2'b11 && bus_start_n, req, "strobes idle",
            {bus_rd_n, bus_we_n, bus_start_n}, 4'hF);
        chk(!bus_data_oe && !done && !bus_dack && req_ready, req, "oe/done/dack/ready",
            {bus_data_oe, done, bus_dack, req_ready}, 4'b0001);
    endtask

    task automatic run_one(input int idx, input int space, input bit write, input bit dma,
                           input bit pol, input int field, input int k,
                           input bit hold_req, input bit flip);
        int act_cnt = 0, starts = 0, start_at = 0, last_act = 0, done_at = 0;
        bit got_done = 0, cs_ok = 1, str_ok = 1, addr_ok = 1, dack_ok = 1, ready_ok = 1;
        int nrel, exp_len;
        logic [23:0] a  = 24'(24'h400000 + idx * 24'h010203);
        logic [15:0] wd = 16'(16'hBEEF ^ (idx * 16'h1357));
        logic [1:0]  be = 2'(idx % 3 + 1);
        logic [15:0] exp_rd = '0;
        logic        dack_act = dma ? ~pol : pol;

        nrel    = (field == 0) ? 1 : (field == 1) ? 2 : 4;
        exp_len = 3 + k + ((space == 4) ? nrel - 1 : 0);

        @(negedge clk);
        req_valid = 1'b1; req_write = write; req_space = 3'(space);
        req_addr = a; req_wdata = wd; req_be = be; req_dma = dma;
        cfg_dack_low = pol; cfg_tail_sel = 2'(field); bus_wait_n = 1'b1;

        for (int n = 1; n <= 40 && !got_done; n++) begin
            @(negedge clk);
            if (done) begin
                got_done = 1; done_at = n;
                ready_ok &= req_ready;
                dack_ok  &= (bus_dack == pol);
            end
            if (bus_cs_n != 5'h1F) begin
                act_cnt++; last_act = n;
                cs_ok    &= (bus_cs_n == ~(5'b1 << space));
                addr_ok  &= (bus_addr == a);
                ready_ok &= !req_ready;
                dack_ok  &= (bus_dack == dack_act);
                if (write) str_ok &= bus_rd_n && (bus_we_n == ~be) && bus_data_oe && (bus_data_out == wd);
                else       str_ok &= !bus_rd_n && (bus_we_n == 2'b11) && !bus_data_oe;
                exp_rd = pat(n, idx);
            end else if (!done) begin
                cs_ok &= (n > 1);
            end
            if (!bus_start_n) begin starts++; start_at = n; end
            // drive for this cycle
            if (!hold_req && n == 1) req_valid = 1'b0;
            if (hold_req) begin
                req_addr  = ~a;
                req_space = 3'((space + 1) % 5);
            end
            if (done) req_valid = 1'b0;
            if (flip && n == 2) begin
                cfg_tail_sel = ~2'(field);
                cfg_dack_low = ~pol;
            end
            bus_wait_n  = !(n >= 2 && n <= k + 1);
            bus_data_in = pat(n, idx);
        end

        chk(starts == 1 && start_at == 1, "R3", "start pulse count/cycle", starts * 100 + start_at, 101);
        chk(cs_ok, "R3", "chip-select pattern", bus_cs_n, ~(5'b1 << space));
        if (space == 4)
            chk(act_cnt == exp_len, flip ? "R5/R10" : "R5", "space4 access length", act_cnt, exp_len);
        else
            chk(act_cnt == exp_len, "R4", "access length", act_cnt, exp_len);
        if (k == 0) chk(act_cnt >= 3, "R6", "minimum one wait cycle", act_cnt, 3);
        chk(str_ok, write ? "R8" : "R7", "strobes/oe/data during access", str_ok, 1);
        chk(addr_ok, "R8", "address held", addr_ok, 1);
        chk(dack_ok, flip ? "R9/R10" : "R9", "dma acknowledge levels", dack_ok, 1);
        chk(ready_ok, hold_req ? "R2 held" : "R2", "ready only when idle", ready_ok, 1);
        chk(got_done && done_at == last_act + 1, "R11", "done cycle", done_at, last_act + 1);
        if (!write && got_done)
            chk(rdata == exp_rd, "R7", "read data capture", rdata, exp_rd);

        @(negedge clk);
        chk(!done && bus_cs_n == 5'h1F, hold_req ? "R2/R11" : "R11",
            "single done, no extra access", {done, bus_cs_n}, 6'h1F);
        bus_wait_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "WATCHDOG", "run did not finish", 0, 1);
        report();
    end

    initial begin
        int idx = 0;
        repeat (3) @(negedge clk);
        check_idle_outputs("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_outputs("R1");

        for (int sp = 0; sp < 5; sp++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int k = 0; k < 4; k++) begin
                    for (int f = 0; f < ((sp == 4) ? 4 : 1); f++) begin
                        run_one(idx, sp, wr[0], idx[0], idx[1],
                                (sp == 4) ? f : idx % 4, k,
                                (idx % 5) == 3, (idx % 3) == 1);
                        idx++;
                    end
                end
            end
        end
        report();
    end

endmodule